// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block is the bus-master transmit side of a three-wire serial audio link. A parallel source hands it stereo pairs of signed PCM samples through a valid/ready handshake. The block turns each pair into a serial bit stream with a word-select strobe. The master clock input is forwarded unchanged as the serial bit clock. Word select has a fixed period of 512 master-clock cycles, so each channel half-frame holds 256 bit slots. The sample only fills part of those slots.

The block offers four placement rules for the sample inside the frame:
- standard I2S: the MSB comes one slot after the word-select edge;
- left-justified: the MSB comes in the first slot after the edge;
- right-justified: the LSB sits in the last slot of the half-frame;
- DSP: a one-slot frame pulse, followed at once by the left sample and then the right sample.

The sample resolution can be 8, 16, 24 or 32 bits. Format and resolution are taken from plain control pins at each frame boundary.

Back-pressure works as follows. `in_ready` is high for one master-clock cycle per frame, in the last slot. A pair is accepted on a rising edge where both `in_valid` and `in_ready` are high. The source holds its data and `in_valid` until that edge. If no pair is offered at the boundary, the frame carries zeros and a sticky underrun flag is raised.

Top module: `audio_serial_tx`

## Requirements
- R1: `sck_o` is the master clock `mclk` itself, with no division.
- R2: In the I2S, left-justified and right-justified formats, `ws_o` is 0 for frame slots 0..255 (left channel) and 1 for slots 256..511 (right channel).
- R3: In format code 0 (I2S), the sample MSB is in slot 1 of its half-frame, and the following bits take the next slots, MSB first.
- R4: In format code 1 (left-justified), the sample MSB is in slot 0 of its half-frame.
- R5: In format code 2 (right-justified), the sample LSB is in the last slot (slot 255) of its half-frame.
- R6: In format code 3 (DSP), `ws_o` is 1 only in frame slot 0. The left sample starts in slot 1, and the right sample starts in the slot right after the left LSB.
- R7: Every slot not taken by a sample bit drives `sd_o` to 0.
- R8: The resolution code k (0..3) selects a width of 8·(k+1) bits. The sample is taken from bits [width-1:0] of `in_left` and `in_right` and sent MSB first in two's complement.
- R9: `in_ready` is high for exactly one cycle in every 512, in the last slot of the frame. A pair is accepted only on a rising edge where both `in_valid` and `in_ready` are high.
- R10: If `in_valid` is low at the frame boundary, the next frame sends all zeros and `underrun_o` rises. The flag stays set until an `underrun_clr` pulse clears it. A new underrun in the same cycle as a clear keeps the flag set.
- R11: `cfg_fmt` and `cfg_res` are sampled only at the frame boundary. Changes in the middle of a frame have no effect on that frame.
- R12: `sd_o` and `ws_o` change only on the falling edge of `mclk`, so they are stable around each rising edge.
- R13: While `rst_n` is low (synchronous, active low), `in_ready`, `sd_o`, `ws_o` and `underrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all logic runs from it |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Source offers a sample pair |
| in_ready | output | 1 | Block accepts a pair this cycle (last frame slot) |
| in_left | input | 32 | Left sample, low bits used per resolution |
| in_right | input | 32 | Right sample, low bits used per resolution |
| cfg_fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| cfg_res | input | 2 | 0/1/2/3 for 8/16/24/32-bit samples |
| underrun_clr | input | 1 | One-cycle pulse clears the underrun flag |
| sck_o | output | 1 | Serial bit clock (equals mclk) |
| ws_o | output | 1 | Word select or DSP frame pulse |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench targets the edges of each placement rule:
- the slot-0 versus slot-1 start that separates I2S from left-justified, where an off-by-one design shifts every bit and drops or duplicates the LSB;
- the 8-bit right-justified sample, which a design with wrong end arithmetic places into the wrong slots;
- the DSP right sample, which must follow the left LSB with no gap, for both the 8-bit and 32-bit widths.

It changes format and data inputs in the middle of a frame to catch a design that samples them outside the boundary. It also runs an underrun followed by a valid frame, to catch a flag that is not sticky, is cleared by new data, or lets stale samples through instead of zeros.

// File: rtl/ast_pkg.sv
`timescale 1ns/1ps
package ast_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;
endpackage

// File: rtl/ast_frame_timer.sv
`timescale 1ns/1ps
module ast_frame_timer #(
  parameter int FRAME_SLOTS = 512
) (
  input  logic                           clk,
  input  logic                           rst_n,
  output logic [$clog2(FRAME_SLOTS)-1:0] slot,
  output logic                           last
);
  localparam int CNT_W = $clog2(FRAME_SLOTS);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_SLOTS - 1);

  assign last = (slot == LAST_SLOT);

  // Reset parks the counter on the last slot so the first frame starts right after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) slot <= LAST_SLOT;
    else if (last) slot <= '0;
    else slot <= slot + CNT_W'(1);
  end
endmodule

// File: rtl/ast_sample_latch.sv
`timescale 1ns/1ps
module ast_sample_latch #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  ast_pkg::fmt_e       cfg_fmt,
  input  logic [1:0]          cfg_res,
  input  logic                clr,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output ast_pkg::fmt_e       fmt_q,
  output logic [1:0]          res_q,
  output logic                underrun
);
  localparam int STEP = SAMPLE_W / 4;

  // Stored words are MSB-aligned so the serializer always starts at the top bit.
  function automatic logic [SAMPLE_W-1:0] msb_align(input logic [SAMPLE_W-1:0] v,
                                                    input logic [1:0] r);
    int sh;
    sh = SAMPLE_W - (int'(r) + 1) * STEP;
    return v << sh;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q   <= '0;
      right_q  <= '0;
      fmt_q    <= ast_pkg::FMT_I2S;
      res_q    <= 2'd3;
      underrun <= 1'b0;
    end else begin
      if (clr) underrun <= 1'b0;
      if (boundary) begin
        fmt_q <= cfg_fmt;
        res_q <= cfg_res;
        if (in_valid) begin
          left_q  <= msb_align(in_left, cfg_res);
          right_q <= msb_align(in_right, cfg_res);
        end else begin
          left_q   <= '0;
          right_q  <= '0;
          underrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ast_slot_mapper.sv
`timescale 1ns/1ps
module ast_slot_mapper #(
  parameter int FRAME_SLOTS = 512,
  parameter int SAMPLE_W    = 32
) (
  input  logic [$clog2(FRAME_SLOTS)-1:0] slot,
  input  ast_pkg::fmt_e                  fmt,
  input  logic [1:0]                     res,
  input  logic [SAMPLE_W-1:0]            left_q,
  input  logic [SAMPLE_W-1:0]            right_q,
  output logic                           sd_bit,
  output logic                           ws_bit
);
  localparam int CNT_W = $clog2(FRAME_SLOTS);
  localparam int XW    = CNT_W + 1;
  localparam int HALF  = FRAME_SLOTS / 2;
  localparam int STEP  = SAMPLE_W / 4;

  logic [XW-1:0]       w, s, off, k;
  logic                hit, in_right;
  logic [SAMPLE_W-1:0] src;

  // Returns bit number k counted from the MSB of an MSB-aligned word.
  function automatic logic pick(input logic [SAMPLE_W-1:0] v, input logic [XW-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++)
      if (idx == XW'(i)) r = v[SAMPLE_W-1-i];
    return r;
  endfunction

  always_comb begin
    w        = XW'(res) * XW'(STEP) + XW'(STEP);
    s        = {1'b0, slot};
    in_right = slot[CNT_W-1];
    off      = {2'b00, slot[CNT_W-2:0]};
    hit      = 1'b0;
    k        = '0;
    ws_bit   = in_right;
    src      = in_right ? right_q : left_q;
    unique case (fmt)
      ast_pkg::FMT_I2S: begin
        if (off != '0 && off <= w) begin
          hit = 1'b1;
          k   = off - XW'(1);
        end
      end
      ast_pkg::FMT_LJ: begin
        if (off < w) begin
          hit = 1'b1;
          k   = off;
        end
      end
      ast_pkg::FMT_RJ: begin
        if (off >= XW'(HALF) - w) begin
          hit = 1'b1;
          k   = off - (XW'(HALF) - w);
        end
      end
      ast_pkg::FMT_DSP: begin
        ws_bit = (s == '0);
        src    = left_q;
        if (s != '0 && s <= w) begin
          hit = 1'b1;
          k   = s - XW'(1);
        end else if (s > w && s <= (w << 1)) begin
          hit = 1'b1;
          k   = s - w - XW'(1);
          src = right_q;
        end
      end
    endcase
    sd_bit = hit & pick(src, k);
  end
endmodule

// File: rtl/audio_serial_tx.sv
`timescale 1ns/1ps
module audio_serial_tx #(
  parameter int FRAME_SLOTS = 512,
  parameter int SAMPLE_W    = 32
) (
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_res,
  input  logic                underrun_clr,
  output logic                sck_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  localparam int CNT_W = $clog2(FRAME_SLOTS);

  logic [CNT_W-1:0]    slot;
  logic                frame_last;
  logic [SAMPLE_W-1:0] left_q, right_q;
  ast_pkg::fmt_e       fmt_q;
  logic [1:0]          res_q;
  logic                sd_bit, ws_bit;

  assign sck_o    = mclk;
  assign in_ready = frame_last & rst_n;

  ast_frame_timer #(.FRAME_SLOTS(FRAME_SLOTS)) u_timer (
    .clk  (mclk),
    .rst_n(rst_n),
    .slot (slot),
    .last (frame_last)
  );

  ast_sample_latch #(.SAMPLE_W(SAMPLE_W)) u_latch (
    .clk     (mclk),
    .rst_n   (rst_n),
    .boundary(frame_last),
    .in_valid(in_valid),
    .in_left (in_left),
    .in_right(in_right),
    .cfg_fmt (ast_pkg::fmt_e'(cfg_fmt)),
    .cfg_res (cfg_res),
    .clr     (underrun_clr),
    .left_q  (left_q),
    .right_q (right_q),
    .fmt_q   (fmt_q),
    .res_q   (res_q),
    .underrun(underrun_o)
  );

  ast_slot_mapper #(.FRAME_SLOTS(FRAME_SLOTS), .SAMPLE_W(SAMPLE_W)) u_map (
    .slot   (slot),
    .fmt    (fmt_q),
    .res    (res_q),
    .left_q (left_q),
    .right_q(right_q),
    .sd_bit (sd_bit),
    .ws_bit (ws_bit)
  );

  // Line outputs are retimed on the falling edge so that they are stable at the receiver's rising edge.
  always_ff @(negedge mclk) begin
    if (!rst_n) begin
      sd_o <= 1'b0;
      ws_o <= 1'b0;
    end else begin
      sd_o <= sd_bit;
      ws_o <= ws_bit;
    end
  end
endmodule

// File: rtl/ast_checker.sv
`timescale 1ns/1ps
module ast_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       in_valid,
  input logic       underrun_clr,
  input logic       underrun,
  input logic       ws_o,
  input logic [1:0] fmt_q
);
  // R9: the ready window lasts one cycle
  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R10: a missing pair at the boundary raises the flag
  a_r10_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> underrun);

  // R10: the flag holds until cleared
  a_r10_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);

  // R10: a clear with no new underrun drops the flag
  a_r10_underrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_clr && !(in_ready && !in_valid)) |=> !underrun);

  // R6: the DSP frame pulse is one slot wide
  a_r6_dsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == 2'd3 && $stable(fmt_q) && ws_o) |=> !ws_o);
endmodule

bind audio_serial_tx ast_checker u_chk (
  .clk         (mclk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .in_valid    (in_valid),
  .underrun_clr(underrun_clr),
  .underrun    (underrun_o),
  .ws_o        (ws_o),
  .fmt_q       (fmt_q)
);

// File: tb/audio_serial_tx_test.sv
`timescale 1ns/1ps
module audio_serial_tx_test;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_left = '0, in_right = '0;
  logic [1:0]  cfg_fmt = 2'd0, cfg_res = 2'd3;
  logic        underrun_clr = 1'b0;
  logic        sck_o, ws_o, sd_o, underrun_o;

  int checks = 0, errors = 0;
  bit done = 0;
  longint cyc = 0;

  always #10 mclk = ~mclk;
  always @(posedge mclk) cyc++;

  audio_serial_tx uut (
    .mclk(mclk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .cfg_fmt(cfg_fmt), .cfg_res(cfg_res),
    .underrun_clr(underrun_clr), .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o),
    .underrun_o(underrun_o)
  );

  // previous frame being checked
  bit          have_prev = 0;
  logic [1:0]  p_f, p_rs;
  logic [31:0] p_l, p_r;
  bit          p_mid;
  int          sd_bad, ws_bad, st_bad, first_bad;
  logic        first_got, first_exp;
  bit          ur_model = 0;
  longint      last_xfer = -1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic exp_sd(input logic [1:0] f, input logic [1:0] rs,
                                  input logic [31:0] l, input logic [31:0] r, input int s);
    int w, o;
    logic [31:0] v;
    w = (int'(rs) + 1) * 8;
    o = s % 256;
    v = (s >= 256) ? r : l;
    case (f)
      2'd0: if (o >= 1 && o <= w) return v[w-o];
      2'd1: if (o < w) return v[w-1-o];
      2'd2: if (o >= 256 - w) return v[255-o];
      default: begin
        if (s >= 1 && s <= w) return l[w-s];
        if (s > w && s <= 2*w) return r[2*w-s];
      end
    endcase
    return 1'b0;
  endfunction

  function automatic logic exp_ws(input logic [1:0] f, input int s);
    if (f == 2'd3) return (s == 0);
    return (s >= 256);
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_slot(input int s, input logic pre_sd, input logic pre_ws);
    logic e;
    e = exp_sd(p_f, p_rs, p_l, p_r, s);
    if (sd_o !== e) begin
      if (sd_bad == 0) begin first_bad = s; first_got = sd_o; first_exp = e; end
      sd_bad++;
    end
    if (ws_o !== exp_ws(p_f, s)) ws_bad++;
    if (pre_sd !== sd_o || pre_ws !== ws_o) st_bad++;
  endtask

  task automatic close_frame;
    string tag;
    tag = {fmt_tag(p_f), " R7 R8", p_mid ? " R11" : ""};
    check(sd_bad == 0, tag, $sformatf("sd slot %0d (fmt %0d res %0d)", first_bad, p_f, p_rs),
          first_got, first_exp);
    check(ws_bad == 0, (p_f == 2'd3) ? "R6" : "R2", "ws mismatching slots", ws_bad, 0);
    check(st_bad == 0, "R12", "outputs moved near rising edge", st_bad, 0);
  endtask

  task automatic run_frame(input logic [1:0] f, input logic [1:0] rs, input logic [31:0] l,
                           input logic [31:0] r, input bit v, input bit midchg, input bit doclr);
    logic pre_sd, pre_ws;
    do @(negedge mclk); while (!in_ready);
    in_valid = v; in_left = l; in_right = r; cfg_fmt = f; cfg_res = rs;
    @(posedge mclk); #1;
    in_valid = 1'b0;
    // R9: one ready window every 512 cycles
    if (last_xfer >= 0) check(cyc - last_xfer == 512, "R9", "ready period", cyc - last_xfer, 512);
    last_xfer = cyc;
    check(in_ready == 1'b0, "R9", "ready after accept", in_ready, 0);
    if (have_prev) begin
      compare_slot(511, sd_o, ws_o);
      close_frame();
    end
    if (!v) ur_model = 1;
    check(underrun_o == ur_model, "R10", "flag at boundary", underrun_o, ur_model);
    have_prev = 1; p_f = f; p_rs = rs; p_l = v ? l : '0; p_r = v ? r : '0; p_mid = midchg;
    sd_bad = 0; ws_bad = 0; st_bad = 0; first_bad = -1; first_got = 0; first_exp = 0;
    for (int k = 0; k < 511; k++) begin
      @(negedge mclk);
      if (midchg && k == 100) begin
        // R11: mid-frame changes must not reach the line
        cfg_fmt = ~f; cfg_res = ~rs; in_left = ~l; in_right = ~r;
      end
      if (doclr && k == 200) underrun_clr = 1'b1;
      #9; pre_sd = sd_o; pre_ws = ws_o;
      @(posedge mclk); #1;
      underrun_clr = 1'b0;
      if (doclr && k == 200) begin
        ur_model = 0;
        check(underrun_o == 1'b0, "R10", "flag after clear", underrun_o, 0);
      end
      compare_slot(k, pre_sd, pre_ws);
    end
  endtask

  task automatic flush;
    logic pre_sd, pre_ws;
    @(negedge mclk); #9; pre_sd = sd_o; pre_ws = ws_o;
    @(posedge mclk); #1;
    compare_slot(511, pre_sd, pre_ws);
    close_frame();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] rl, rr;
    seed = 32'd20240611;
    rl = $urandom(seed);
    repeat (5) @(posedge mclk);
    #1;
    // R13 reset state, R1 clock forwarding
    check(in_ready == 0 && sd_o == 0 && ws_o == 0 && underrun_o == 0, "R13", "reset outputs",
          {in_ready, sd_o, ws_o, underrun_o}, 0);
    check(sck_o == 1'b1, "R1", "sck high after rising edge", sck_o, 1);
    @(negedge mclk); #1;
    check(sck_o == 1'b0, "R1", "sck low after falling edge", sck_o, 0);
    @(posedge mclk); #1;
    rst_n = 1'b1;

    run_frame(2'd0, 2'd3, 32'h8000_0001, 32'h7FFF_FFFE, 1, 0, 0);   // R3 32-bit
    run_frame(2'd0, 2'd1, 32'h0000_A5C3, 32'h0000_3C5A, 1, 0, 0);   // R3 16-bit
    run_frame(2'd1, 2'd2, 32'h00F0_0F81, 32'h0081_0FF0, 1, 0, 0);   // R4 24-bit
    run_frame(2'd2, 2'd0, 32'hFFFF_FF81, 32'h0000_0001, 1, 0, 0);   // R5 8-bit
    run_frame(2'd2, 2'd3, 32'h8000_0001, 32'hC000_0003, 1, 0, 0);   // R5 32-bit
    run_frame(2'd3, 2'd3, 32'hF000_000F, 32'h8000_0001, 1, 0, 0);   // R6 32-bit
    run_frame(2'd3, 2'd0, 32'h0000_0081, 32'h0000_00FF, 1, 0, 0);   // R6 8-bit
    run_frame(2'd1, 2'd0, 32'h0000_00C3, 32'h0000_0055, 1, 1, 0);   // R11
    run_frame(2'd0, 2'd1, 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0);   // R10 underrun -> zeros
    run_frame(2'd1, 2'd1, 32'h0000_1234, 32'h0000_8765, 1, 0, 1);   // R10 sticky, then clear

    for (int i = 0; i < 12; i++) begin
      rl = $urandom();
      rr = $urandom();
      run_frame(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), rl, rr,
                ($urandom_range(0, 5) != 0), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 2) == 0));
    end
    flush();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule